// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block is the digital counting core of an integer-N synthesizer loop. A 32/33 dual-modulus prescaler is steered by a 7-bit programmable counter and a 5-bit swallow counter. Together they emit one pulse every `32*N + A` qualified input cycles. A separate 5-bit counter divides a reference enable stream by R. The two pulse trains feed a phase detector, which lies outside this block.

Both inputs arrive as clock-enable streams on the one system clock: `vco_en` marks a VCO cycle and `ref_en` marks a reference cycle. A one-cycle `load` strobe presents a new set of N, A and R. Legal values are held pending, and each divider adopts them at its next terminal count, so no period is ever cut short or stretched. An illegal set is dropped whole and raises `cfg_err`.

Top module: `swallow_divider`

## Requirements
- R1: After synchronous reset, `vco_pulse`, `ref_pulse` and `cfg_err` are 0, and the dividers run with N=75, A=0, R=12 (a VCO ratio of 2400).
- R2: `vco_pulse` is a single-cycle pulse. It rises in the clock cycle after the `vco_en` cycle that ends a period. Consecutive pulses are exactly `32*N + A` asserted `vco_en` cycles apart.
- R3: In every period, the first A prescaler cycles count 33 enables each and the remaining N-A count 32. With A=0 the gap is exactly `32*N`, and with A=N it is exactly `33*N`.
- R4: Cycles with `vco_en` low do not advance the VCO chain. A pulse never appears unless `vco_en` was high in the cycle before.
- R5: `ref_pulse` is a single-cycle pulse one clock after every R-th asserted `ref_en` cycle.
- R6: Values accepted by `load` take effect only when each divider next reaches its terminal count. The period that is running finishes with its old ratio.
- R7: A load is illegal when N < A, when N = 0, or when R lies outside 5..20. An illegal load changes nothing except setting `cfg_err` to 1 in the next cycle. A legal load clears `cfg_err` in the next cycle.
- R8: `cfg_err` changes only in the cycle after a `load`. Because every legal ratio is at least 32 and every legal R is at least 5, neither pulse output is ever high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vco_en | input | 1 | Qualifies one VCO input cycle |
| ref_en | input | 1 | Qualifies one reference input cycle |
| load | input | 1 | One-cycle strobe that samples n_val, a_val and r_val |
| n_val | input | 7 | Programmable counter value N |
| a_val | input | 5 | Swallow counter value A |
| r_val | input | 5 | Reference divide value R |
| vco_pulse | output | 1 | Divided VCO pulse, one cycle wide |
| ref_pulse | output | 1 | Divided reference pulse, one cycle wide |
| cfg_err | output | 1 | Last load was rejected as illegal |

## Verification
The gap properties assume that a legal ratio is never below 32 and a legal R never below 5. This holds because the block itself rejects any other load, so the bench can also drive illegal strobes without breaking the properties. The error-flag properties assume that `load` is a single-cycle strobe with the value fields stable alongside it. The bench drives every input on the falling edge and raises `load` for exactly one cycle. The enable streams are held high, held low, or thinned pseudo-randomly, which produces stalls at arbitrary points inside prescaler cycles.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  localparam int N_W = 7;
  localparam int A_W = 5;
  localparam int R_W = 5;

  typedef struct packed {
    logic [N_W-1:0] n;
    logic [A_W-1:0] a;
    logic [R_W-1:0] r;
  } swdiv_cfg_t;
endpackage

// File: rtl/swdiv_cfg.sv
module swdiv_cfg
  import swdiv_pkg::*;
#(
  parameter int R_MIN = 5,
  parameter int R_MAX = 20,
  parameter int DEF_N = 75,
  parameter int DEF_A = 0,
  parameter int DEF_R = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  swdiv_cfg_t cfg_in,
  output swdiv_cfg_t cfg_pend,
  output logic       cfg_err
);
  localparam logic [R_W-1:0] R_LO = R_MIN[R_W-1:0];
  localparam logic [R_W-1:0] R_HI = R_MAX[R_W-1:0];

  logic legal;

  // A set is accepted only whole: swallow count within N, N non-zero, R in range
  always_comb begin
    legal = (cfg_in.n >= N_W'(cfg_in.a)) && (cfg_in.n != '0)
         && (cfg_in.r >= R_LO) && (cfg_in.r <= R_HI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_pend.n <= DEF_N[N_W-1:0];
      cfg_pend.a <= DEF_A[A_W-1:0];
      cfg_pend.r <= DEF_R[R_W-1:0];
      cfg_err    <= 1'b0;
    end else if (load) begin
      if (legal) begin
        cfg_pend <= cfg_in;
        cfg_err  <= 1'b0;
      end else begin
        cfg_err  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler #(
  parameter int BASE_MOD = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic mc,
  output logic tick
);
  localparam int PW = $clog2(BASE_MOD + 1);
  localparam logic [PW-1:0] LAST_LO = PW'(BASE_MOD - 1);
  localparam logic [PW-1:0] LAST_HI = PW'(BASE_MOD);

  logic [PW-1:0] cnt;
  logic          at_last;

  // mc high selects the long modulus (BASE_MOD + 1)
  assign at_last = mc ? (cnt == LAST_HI) : (cnt == LAST_LO);
  assign tick    = en && at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= at_last ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/swdiv_swallow_ctr.sv
module swdiv_swallow_ctr
  import swdiv_pkg::*;
#(
  parameter int DEF_N = 75,
  parameter int DEF_A = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [N_W-1:0] pend_n,
  input  logic [A_W-1:0] pend_a,
  output logic           mc,
  output logic           terminal
);
  logic [N_W-1:0] prog_cnt;
  logic [A_W-1:0] swal_cnt;

  assign mc       = (swal_cnt != '0);
  assign terminal = tick && (prog_cnt == N_W'(1));

  // Both counters count down once per prescaler cycle; reload from pending at terminal
  always_ff @(posedge clk) begin
    if (rst) begin
      prog_cnt <= DEF_N[N_W-1:0];
      swal_cnt <= DEF_A[A_W-1:0];
    end else if (terminal) begin
      prog_cnt <= pend_n;
      swal_cnt <= pend_a;
    end else if (tick) begin
      prog_cnt <= prog_cnt - 1'b1;
      if (swal_cnt != '0) swal_cnt <= swal_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/swdiv_ref_div.sv
module swdiv_ref_div
  import swdiv_pkg::*;
#(
  parameter int DEF_R = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [R_W-1:0] pend_r,
  output logic           pulse
);
  logic [R_W-1:0] cnt;
  logic           done;

  assign done = en && (cnt == R_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= DEF_R[R_W-1:0];
      pulse <= 1'b0;
    end else begin
      pulse <= done;
      if (done)    cnt <= pend_r;
      else if (en) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swdiv_pkg::*;
#(
  parameter int BASE_MOD = 32,
  parameter int R_MIN    = 5,
  parameter int R_MAX    = 20,
  parameter int DEF_N    = 75,
  parameter int DEF_A    = 0,
  parameter int DEF_R    = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           vco_en,
  input  logic           ref_en,
  input  logic           load,
  input  logic [N_W-1:0] n_val,
  input  logic [A_W-1:0] a_val,
  input  logic [R_W-1:0] r_val,
  output logic           vco_pulse,
  output logic           ref_pulse,
  output logic           cfg_err
);
  swdiv_cfg_t cfg_in;
  swdiv_cfg_t cfg_pend;
  logic       mc;
  logic       pre_tick;
  logic       terminal;

  assign cfg_in = '{n: n_val, a: a_val, r: r_val};

  swdiv_cfg #(
    .R_MIN(R_MIN), .R_MAX(R_MAX), .DEF_N(DEF_N), .DEF_A(DEF_A), .DEF_R(DEF_R)
  ) u_cfg (
    .clk(clk), .rst(rst), .load(load), .cfg_in(cfg_in),
    .cfg_pend(cfg_pend), .cfg_err(cfg_err)
  );

  swdiv_prescaler #(.BASE_MOD(BASE_MOD)) u_pre (
    .clk(clk), .rst(rst), .en(vco_en), .mc(mc), .tick(pre_tick)
  );

  swdiv_swallow_ctr #(.DEF_N(DEF_N), .DEF_A(DEF_A)) u_ctr (
    .clk(clk), .rst(rst), .tick(pre_tick),
    .pend_n(cfg_pend.n), .pend_a(cfg_pend.a),
    .mc(mc), .terminal(terminal)
  );

  swdiv_ref_div #(.DEF_R(DEF_R)) u_ref (
    .clk(clk), .rst(rst), .en(ref_en), .pend_r(cfg_pend.r), .pulse(ref_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) vco_pulse <= 1'b0;
    else     vco_pulse <= terminal;
  end
endmodule

// File: rtl/swdiv_chk.sv
module swdiv_chk #(
  parameter int R_MIN = 5,
  parameter int R_MAX = 20
) (
  input logic       clk,
  input logic       rst,
  input logic       vco_en,
  input logic       load,
  input logic [6:0] n_val,
  input logic [4:0] a_val,
  input logic [4:0] r_val,
  input logic       vco_pulse,
  input logic       ref_pulse,
  input logic       cfg_err
);
  logic bad_set;
  assign bad_set = (int'(n_val) < int'(a_val)) || (n_val == 7'd0)
                || (int'(r_val) < R_MIN) || (int'(r_val) > R_MAX);

  // R7
  bad_load_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (load && bad_set) |=> cfg_err);

  // R7
  good_load_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !bad_set) |=> !cfg_err);

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cfg_err));

  // R8
  vco_gap_chk: assert property (@(posedge clk) disable iff (rst)
    vco_pulse |=> !vco_pulse);

  // R8
  ref_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ref_pulse |=> !ref_pulse);

  // R4
  vco_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    vco_pulse |-> $past(vco_en));
endmodule

bind swallow_divider swdiv_chk #(.R_MIN(R_MIN), .R_MAX(R_MAX)) u_chk (
  .clk(clk), .rst(rst), .vco_en(vco_en), .load(load),
  .n_val(n_val), .a_val(a_val), .r_val(r_val),
  .vco_pulse(vco_pulse), .ref_pulse(ref_pulse), .cfg_err(cfg_err)
);

// File: tb/swallow_divider_tb.sv
module swallow_divider_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vco_en = 1'b0, ref_en = 1'b0, load = 1'b0;
  logic [6:0] n_val = '0;
  logic [4:0] a_val = '0, r_val = '0;
  logic vco_pulse, ref_pulse, cfg_err;

  int checks = 0, fails = 0;
  int vmode = 0, rmode = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  swallow_divider u_dut (
    .clk(clk), .rst(rst), .vco_en(vco_en), .ref_en(ref_en), .load(load),
    .n_val(n_val), .a_val(a_val), .r_val(r_val),
    .vco_pulse(vco_pulse), .ref_pulse(ref_pulse), .cfg_err(cfg_err)
  );

  // enable stream generators: 0 off, 1 always, 2 pseudo-random
  always @(negedge clk) begin
    vco_en <= (vmode == 1) ? 1'b1 : (vmode == 2) ? (($urandom % 4) != 0) : 1'b0;
    ref_en <= (rmode == 1) ? 1'b1 : (rmode == 2) ? (($urandom % 3) != 0) : 1'b0;
  end

  // behavioural reference model
  int pn = 75, pa = 0, pr = 12;
  int ratio = 2400, vcnt = 0, rdiv = 12, rcnt = 0;
  bit exp_vp = 0, exp_rp = 0, exp_err = 0;
  always @(posedge clk) begin
    if (rst) begin
      pn = 75; pa = 0; pr = 12; ratio = 2400; rdiv = 12;
      vcnt = 0; rcnt = 0; exp_vp = 0; exp_rp = 0; exp_err = 0;
    end else begin
      exp_vp = 0; exp_rp = 0;
      if (vco_en) begin
        vcnt++;
        if (vcnt == ratio) begin exp_vp = 1; vcnt = 0; ratio = 32 * pn + pa; end
      end
      if (ref_en) begin
        rcnt++;
        if (rcnt == rdiv) begin exp_rp = 1; rcnt = 0; rdiv = pr; end
      end
      if (load) begin
        if (int'(n_val) >= int'(a_val) && n_val != 0 && r_val >= 5 && r_val <= 20) begin
          pn = n_val; pa = a_val; pr = r_val; exp_err = 0;
        end else exp_err = 1;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) if (!rst && !finished) begin
    check("R2 R3 R4 R6 vco_pulse", vco_pulse, exp_vp);
    check("R5 R6 ref_pulse", ref_pulse, exp_rp);
    check("R7 R8 cfg_err", cfg_err, exp_err);
  end

  // measured enable gap between DUT pulses
  int en_since = 0, last_gap = 0, gap_cnt = 0;
  always @(posedge clk) if (!rst && vco_en) en_since++;
  always @(negedge clk) if (!rst && vco_pulse) begin
    last_gap = en_since; en_since = 0; gap_cnt++;
  end

  task automatic expect_gap(string req, int exp);
    int c = gap_cnt;
    while (gap_cnt < c + 2) @(negedge clk);
    check(req, last_gap, exp);
  endtask

  task automatic do_load(int n, int a, int r);
    @(negedge clk);
    n_val = 7'(n); a_val = 5'(a); r_val = 5'(r); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 vco_pulse reset", vco_pulse, 0);
    check("R1 ref_pulse reset", ref_pulse, 0);
    check("R1 cfg_err reset", cfg_err, 0);
    vmode = 1; rmode = 1;
    expect_gap("R1 default ratio", 2400);

    // R2 general case
    do_load(2, 1, 5);
    expect_gap("R2 N=2 A=1", 65);
    // R3 A=0 and A=N
    do_load(3, 0, 7);
    expect_gap("R3 A=0", 96);
    do_load(4, 4, 20);
    expect_gap("R3 A=N", 132);

    // R4 stalls inside prescaler cycles
    vmode = 2; rmode = 2;
    do_load(5, 17 % 6, 9);
    expect_gap("R4 random enables", 32 * 5 + 5);
    vmode = 0;
    begin
      int seen = 0;
      repeat (300) begin @(negedge clk); if (vco_pulse) seen++; end
      check("R4 no pulse with enable low", seen, 0);
    end
    vmode = 1;

    // R7 illegal loads keep old values
    do_load(1, 3, 10);
    check("R7 N<A flags", cfg_err, 1);
    expect_gap("R7 ratio kept after N<A", 165);
    do_load(0, 0, 10);
    check("R7 N=0 flags", cfg_err, 1);
    do_load(6, 2, 21);
    check("R7 R too large flags", cfg_err, 1);
    do_load(6, 2, 4);
    check("R7 R too small flags", cfg_err, 1);
    expect_gap("R7 ratio kept after bad R", 165);
    do_load(2, 2, 5);
    check("R7 legal load clears", cfg_err, 0);

    // R6 loads mid-period apply only at the next terminal count
    do_load(6, 31 % 7, 6);
    repeat (20) @(negedge clk);
    do_load(3, 1, 8);
    expect_gap("R6 last load wins", 97);
    rmode = 2; vmode = 2;
    do_load(7, 6, 13);
    expect_gap("R6 R2 random", 230);

    repeat (200) @(negedge clk);
    finish_run();
  end
endmodule